// File: doc/BRIEF.md
# Plane-Mode Intra Sample Predictor

This block produces the plane-mode intra prediction for one block of a video decoder. A single gradient datapath and a single sample generator serve both the 16x16 luma block and the chroma blocks of all three sampling formats. The caller presents the top-row and left-column neighbour samples, the top-left corner sample and the block kind, then pulses `start`. The block copies those inputs into its own registers and runs a setup phase. That phase accumulates the horizontal and vertical gradient sums one weighted term per cycle, then turns them into the offset `a` and the slopes `b` and `c`.

After setup, every cycle can emit one complete 4x4 tile of predicted samples. The tile is presented on a valid/ready output together with its tile column and row. Within a tile, samples grow from one corner by repeated addition of `b` along a row and `c` down a column, so no per-sample multiply is needed. Adding the residual and storing the reconstruction are left to the surrounding pipeline.

Top module: `plane_pred_top`

## Requirements
- R1: While reset is held and after it is released, `busy` and `out_valid` are low until a block is started.
- R2: The block size is 16 wide by 16 tall when `is_chroma` is 0. For chroma it depends on `chroma_fmt`: code 2'd3 gives 16x16, code 2'd2 gives 8 wide by 16 tall, and any other code gives 8x8. Exactly (width/4)*(height/4) tiles are emitted, in raster order with `out_bx` advancing first and then `out_by`. `out_last` is high on the final tile only.
- R3: With W the block width and N = W/2, the horizontal gradient is H = sum over k = 1..N of k*(T[N-1+k] - T[N-1-k]), where T[-1] stands for the corner sample. The vertical gradient V is formed the same way from the left column, using the block height.
- R4: a = 16*(L[height-1] + T[width-1]). b = (m*H + 32) >> 6, with m = 5 when the width is 16 and m = 34 when it is 8; the shift is arithmetic. c is formed the same way from V and the height.
- R5: The sample at column x, row y is clip((a + b*(x-xc) + c*(y-yc) + 16) >> 5). xc is 7 for a width of 16 and 3 for a width of 8; yc follows the same rule from the height. clip saturates to 0..255.
- R6: In `out_tile`, the sample at column i, row j of the tile occupies bits [(4*j+i)*8 +: 8]. The tile sits at block column 4*`out_bx` and block row 4*`out_by`. Top-row sample x is at `top_row[x*8 +: 8]` and left sample y is at `left_col[y*8 +: 8]`.
- R7: While `out_valid` is high and `out_ready` is low, `out_tile`, `out_bx`, `out_by`, `out_last` and `out_valid` hold their values into the next cycle.
- R8: The neighbour, kind and format inputs are sampled only on the cycle `start` is accepted while idle. A `start` pulse seen while `busy` is high, including the cycle of the last tile's handshake, is ignored and produces no output.
- R9: `busy` rises on the clock edge that accepts `start` and falls on the edge that completes the last tile's handshake. The first `out_valid` appears exactly width/2 + height/2 + 2 clock edges after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block; honoured only while idle |
| is_chroma | input | 1 | 0 selects luma, 1 selects chroma |
| chroma_fmt | input | 2 | Chroma sampling format code |
| top_row | input | 128 | Sixteen top neighbour samples |
| left_col | input | 128 | Sixteen left neighbour samples |
| corner | input | 8 | Top-left neighbour sample |
| out_ready | input | 1 | Consumer accepts the current tile |
| busy | output | 1 | A block is in setup or being emitted |
| out_valid | output | 1 | `out_tile` holds a tile |
| out_tile | output | 128 | Sixteen predicted samples of one 4x4 tile |
| out_bx | output | 2 | Tile column within the block |
| out_by | output | 2 | Tile row within the block |
| out_last | output | 1 | Marks the final tile of the block |

## Verification
Two events can land in the same cycle: the handshake that retires the final tile, and a fresh `start` from a caller that reacts to `out_last`. The bench provokes this with `out_ready` held high, raising `start` exactly in the cycle where the last tile is being accepted. It then confirms that `busy` and `out_valid` stay low for a full setup interval afterwards. A second overlap is a back-pressure stall landing in the same cycle the generator would advance. Random `out_ready` gaps trigger it, and every cycle the bench compares the held tile with the one shown before the stall while matching each accepted tile against a formula model.

// File: rtl/plane_pred_pkg.sv
package plane_pred_pkg;

    // Phases of one block: gradient sums, parameter setup, tile emission.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SUMH  = 3'd1,
        PH_SUMV  = 3'd2,
        PH_PARAM = 3'd3,
        PH_EMIT  = 3'd4
    } phase_e;

endpackage

// File: rtl/plane_grad_mac.sv
// Shared weighted-difference accumulator: one term k*(pos-neg) per cycle.
// Used first for the top-row gradient and then for the left-column gradient.
module plane_grad_mac #(
    parameter int unsigned SW = 8,
    parameter int unsigned PW = 20,
    parameter int unsigned KW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic [KW-1:0]        weight,
    input  logic [SW-1:0]        pos_s,
    input  logic [SW-1:0]        neg_s,
    output logic signed [PW-1:0] acc_sum
);

    logic signed [SW:0]      diff;
    logic signed [SW+KW+1:0] term;
    logic signed [PW-1:0]    acc_d, acc_q;

    always_comb begin
        diff    = $signed({1'b0, pos_s}) - $signed({1'b0, neg_s});
        term    = diff * $signed({1'b0, weight});
        acc_sum = acc_q + PW'(term);
        acc_d   = acc_q;
        if (clr) begin
            acc_d = '0;
        end else if (en) begin
            acc_d = acc_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

endmodule

// File: rtl/plane_param_calc.sv
// Turns the two gradient sums and the far neighbours into the plane
// offset and the two slopes. Multipliers are shift-and-add constants.
module plane_param_calc #(
    parameter int unsigned SW = 8,
    parameter int unsigned PW = 20
) (
    input  logic signed [PW-1:0] h_grad,
    input  logic signed [PW-1:0] v_grad,
    input  logic                 w16,
    input  logic                 h16,
    input  logic [SW-1:0]        top_far,
    input  logic [SW-1:0]        left_far,
    output logic signed [PW-1:0] a_o,
    output logic signed [PW-1:0] b_o,
    output logic signed [PW-1:0] c_o
);

    localparam logic signed [PW-1:0] ROUND64 = 32;

    // Wide dimension: times 5; narrow dimension: times 34.
    function automatic logic signed [PW-1:0] slope(input logic signed [PW-1:0] g,
                                                   input logic wide);
        logic signed [PW-1:0] m;
        m = wide ? ((g <<< 2) + g) : ((g <<< 5) + (g <<< 1));
        return (m + ROUND64) >>> 6;
    endfunction

    logic [SW:0] far_sum;

    always_comb begin
        far_sum = {1'b0, top_far} + {1'b0, left_far};
        a_o     = $signed({{(PW-SW-5){1'b0}}, far_sum, 4'b0000});
        b_o     = slope(h_grad, w16);
        c_o     = slope(v_grad, h16);
    end

endmodule

// File: rtl/plane_tile_gen.sv
// Builds one 4x4 tile of plane samples: a single corner value from the
// direct formula, then a chain of additions of c down and b across.
module plane_tile_gen #(
    parameter int unsigned SW   = 8,
    parameter int unsigned PW   = 20,
    parameter int unsigned TS   = 4,
    parameter int unsigned MAXD = 16,
    parameter int unsigned CW   = 2
) (
    input  logic signed [PW-1:0] a_i,
    input  logic signed [PW-1:0] b_i,
    input  logic signed [PW-1:0] c_i,
    input  logic [CW-1:0]        bx,
    input  logic [CW-1:0]        by,
    input  logic                 w16,
    input  logic                 h16,
    output logic [TS*TS*SW-1:0]  tile
);

    localparam int unsigned TSB = $clog2(TS);
    localparam logic signed [PW-1:0] CTR_WIDE   = MAXD/2 - 1;
    localparam logic signed [PW-1:0] CTR_NARROW = MAXD/4 - 1;
    localparam logic signed [PW-1:0] ROUND32    = 16;
    localparam logic signed [PW-1:0] PIX_MAX    = (1 << SW) - 1;

    logic signed [PW-1:0] xo, yo, base;
    logic signed [PW-1:0] acc [TS][TS];
    logic signed [PW-1:0] sh  [TS][TS];

    always_comb begin
        xo   = $signed(PW'({bx, {TSB{1'b0}}})) - (w16 ? CTR_WIDE : CTR_NARROW);
        yo   = $signed(PW'({by, {TSB{1'b0}}})) - (h16 ? CTR_WIDE : CTR_NARROW);
        base = a_i + b_i * xo + c_i * yo + ROUND32;
    end

    for (genvar j = 0; j < TS; j++) begin : g_row
        for (genvar i = 0; i < TS; i++) begin : g_col
            if (i == 0 && j == 0) begin : g_origin
                assign acc[j][i] = base;
            end else if (i == 0) begin : g_down
                assign acc[j][i] = acc[j-1][i] + c_i;
            end else begin : g_across
                assign acc[j][i] = acc[j][i-1] + b_i;
            end
            assign sh[j][i] = acc[j][i] >>> 5;
            assign tile[(j*TS+i)*SW +: SW] =
                (sh[j][i] < 0)       ? '0 :
                (sh[j][i] > PIX_MAX) ? SW'(PIX_MAX) : sh[j][i][SW-1:0];
        end
    end

endmodule

// File: rtl/plane_pred_top.sv
module plane_pred_top
    import plane_pred_pkg::*;
#(
    parameter int unsigned SW   = 8,
    parameter int unsigned MAXD = 16,
    parameter int unsigned TS   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          is_chroma,
    input  logic [1:0]                    chroma_fmt,
    input  logic [MAXD*SW-1:0]            top_row,
    input  logic [MAXD*SW-1:0]            left_col,
    input  logic [SW-1:0]                 corner,
    input  logic                          out_ready,
    output logic                          busy,
    output logic                          out_valid,
    output logic [TS*TS*SW-1:0]           out_tile,
    output logic [$clog2(MAXD/TS)-1:0]    out_bx,
    output logic [$clog2(MAXD/TS)-1:0]    out_by,
    output logic                          out_last
);

    localparam int unsigned PW    = SW + 12;
    localparam int unsigned TILES = MAXD / TS;
    localparam int unsigned CW    = $clog2(TILES);
    localparam int unsigned KW    = $clog2(MAXD/2) + 1;
    localparam int unsigned LW    = $clog2(MAXD);
    localparam int unsigned TW    = TS * TS * SW;

    typedef struct packed {
        phase_e                   ph;
        logic [MAXD-1:0][SW-1:0]  top;
        logic [MAXD-1:0][SW-1:0]  left;
        logic [SW-1:0]            corner;
        logic                     w16;
        logic                     h16;
        logic [KW-1:0]            k;
        logic signed [PW-1:0]     h;
        logic signed [PW-1:0]     v;
        logic signed [PW-1:0]     a;
        logic signed [PW-1:0]     b;
        logic signed [PW-1:0]     c;
        logic [CW-1:0]            bx;
        logic [CW-1:0]            by;
        logic                     issued;
        logic                     ov;
        logic [CW-1:0]            obx;
        logic [CW-1:0]            oby;
        logic                     olast;
        logic [TW-1:0]            tile;
    } regs_t;

    regs_t q, d;

    logic                 mac_clr, mac_en;
    logic [SW-1:0]        mac_pos, mac_neg;
    logic signed [PW-1:0] mac_sum;
    logic signed [PW-1:0] pa, pb, pc;
    logic [TW-1:0]        gen_tile;
    logic [KW-1:0]        nterm_w, nterm_h;
    logic [LW-1:0]        pidx, nidx;
    logic [CW-1:0]        last_col, last_row;
    logic                 term_last, tile_last, fill;

    plane_grad_mac #(.SW(SW), .PW(PW), .KW(KW)) i_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mac_clr),
        .en      (mac_en),
        .weight  (q.k),
        .pos_s   (mac_pos),
        .neg_s   (mac_neg),
        .acc_sum (mac_sum)
    );

    plane_param_calc #(.SW(SW), .PW(PW)) i_param (
        .h_grad   (q.h),
        .v_grad   (q.v),
        .w16      (q.w16),
        .h16      (q.h16),
        .top_far  (q.top[q.w16 ? LW'(MAXD-1) : LW'(MAXD/2-1)]),
        .left_far (q.left[q.h16 ? LW'(MAXD-1) : LW'(MAXD/2-1)]),
        .a_o      (pa),
        .b_o      (pb),
        .c_o      (pc)
    );

    plane_tile_gen #(.SW(SW), .PW(PW), .TS(TS), .MAXD(MAXD), .CW(CW)) i_gen (
        .a_i  (q.a),
        .b_i  (q.b),
        .c_i  (q.c),
        .bx   (q.bx),
        .by   (q.by),
        .w16  (q.w16),
        .h16  (q.h16),
        .tile (gen_tile)
    );

    always_comb begin
        d        = q;
        mac_clr  = 1'b0;
        mac_en   = 1'b0;
        mac_pos  = '0;
        mac_neg  = '0;
        nterm_w  = q.w16 ? KW'(MAXD/2) : KW'(MAXD/4);
        nterm_h  = q.h16 ? KW'(MAXD/2) : KW'(MAXD/4);
        pidx     = '0;
        nidx     = '0;
        term_last = 1'b0;
        last_col = q.w16 ? CW'(TILES-1) : CW'(TILES/2-1);
        last_row = q.h16 ? CW'(TILES-1) : CW'(TILES/2-1);
        tile_last = (q.bx == last_col) && (q.by == last_row);
        fill     = !q.ov || out_ready;

        case (q.ph)
            PH_IDLE: begin
                if (start) begin
                    d.top    = top_row;
                    d.left   = left_col;
                    d.corner = corner;
                    d.w16    = !is_chroma || (chroma_fmt == 2'd3);
                    d.h16    = !is_chroma || chroma_fmt[1];
                    d.k      = KW'(1);
                    d.issued = 1'b0;
                    mac_clr  = 1'b1;
                    d.ph     = PH_SUMH;
                end
            end
            PH_SUMH: begin
                mac_en    = 1'b1;
                term_last = (q.k == nterm_w);
                pidx      = LW'(nterm_w) + LW'(q.k) - LW'(1);
                nidx      = LW'(nterm_w) - LW'(q.k) - LW'(1);
                mac_pos   = q.top[pidx];
                mac_neg   = term_last ? q.corner : q.top[nidx];
                if (term_last) begin
                    d.h     = mac_sum;
                    d.k     = KW'(1);
                    mac_clr = 1'b1;
                    d.ph    = PH_SUMV;
                end else begin
                    d.k = q.k + KW'(1);
                end
            end
            PH_SUMV: begin
                mac_en    = 1'b1;
                term_last = (q.k == nterm_h);
                pidx      = LW'(nterm_h) + LW'(q.k) - LW'(1);
                nidx      = LW'(nterm_h) - LW'(q.k) - LW'(1);
                mac_pos   = q.left[pidx];
                mac_neg   = term_last ? q.corner : q.left[nidx];
                if (term_last) begin
                    d.v  = mac_sum;
                    d.ph = PH_PARAM;
                end else begin
                    d.k = q.k + KW'(1);
                end
            end
            PH_PARAM: begin
                d.a  = pa;
                d.b  = pb;
                d.c  = pc;
                d.bx = '0;
                d.by = '0;
                d.ph = PH_EMIT;
            end
            PH_EMIT: begin
                if (fill) begin
                    if (!q.issued) begin
                        d.tile  = gen_tile;
                        d.obx   = q.bx;
                        d.oby   = q.by;
                        d.olast = tile_last;
                        d.ov    = 1'b1;
                        if (tile_last) begin
                            d.issued = 1'b1;
                        end else if (q.bx == last_col) begin
                            d.bx = '0;
                            d.by = q.by + CW'(1);
                        end else begin
                            d.bx = q.bx + CW'(1);
                        end
                    end else begin
                        d.ov    = 1'b0;
                        d.olast = 1'b0;
                        d.ph    = PH_IDLE;
                    end
                end
            end
            default: begin
                d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.ph != PH_IDLE);
    assign out_valid = q.ov;
    assign out_tile  = q.tile;
    assign out_bx    = q.obx;
    assign out_by    = q.oby;
    assign out_last  = q.olast;

endmodule

// File: rtl/plane_pred_chk.sv
module plane_pred_chk #(
    parameter int unsigned CW = 2,
    parameter int unsigned TW = 128
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          out_valid,
    input logic          out_ready,
    input logic          out_last,
    input logic [CW-1:0] out_bx,
    input logic [CW-1:0] out_by,
    input logic [TW-1:0] out_tile,
    input logic          w16,
    input logic          h16
);

    localparam logic [CW-1:0] NARROW_LAST = CW'((1 << CW) / 2 - 1);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_tile) && $stable(out_bx)
                                    && $stable(out_by) && $stable(out_last));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_valid);

    assert_last_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !busy && !out_valid);

    assert_start_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start |=> busy && !out_valid);

    assert_col_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !w16 |-> out_bx <= NARROW_LAST);

    assert_row_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !h16 |-> out_by <= NARROW_LAST);

endmodule

bind plane_pred_top plane_pred_chk #(.CW(CW), .TW(TW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_last  (out_last),
    .out_bx    (out_bx),
    .out_by    (out_by),
    .out_tile  (out_tile),
    .w16       (q.w16),
    .h16       (q.h16)
);

// File: tb/test_plane_pred_top.sv
`timescale 1ns/1ps
module test_plane_pred_top;

    localparam int SW = 8;
    localparam int MAXD = 16;
    localparam int TS = 4;
    localparam int CW = 2;
    localparam int TW = TS*TS*SW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              is_chroma = 1'b0;
    logic [1:0]        chroma_fmt = 2'd0;
    logic [MAXD*SW-1:0] top_row = '0;
    logic [MAXD*SW-1:0] left_col = '0;
    logic [SW-1:0]     corner = '0;
    logic              out_ready = 1'b0;
    logic              busy, out_valid, out_last;
    logic [TW-1:0]     out_tile;
    logic [CW-1:0]     out_bx, out_by;

    always #2.5 clk = ~clk;

    plane_pred_top #(.SW(SW), .MAXD(MAXD), .TS(TS)) i_plane_pred_top (
        .clk(clk), .rst_n(rst_n), .start(start), .is_chroma(is_chroma),
        .chroma_fmt(chroma_fmt), .top_row(top_row), .left_col(left_col),
        .corner(corner), .out_ready(out_ready), .busy(busy),
        .out_valid(out_valid), .out_tile(out_tile), .out_bx(out_bx),
        .out_by(out_by), .out_last(out_last)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    logic [TW-1:0] q_tile[$];
    int            q_bx[$];
    int            q_by[$];
    bit            q_last[$];

    int tv[MAXD];
    int lv[MAXD];
    int cv;

    bit rdy_mode = 1'b0;
    bit collide_arm = 1'b0;
    bit mon_start_clr = 1'b0;
    bit lat_track = 1'b0;
    int lat_cnt = 0;
    int exp_lat = 0;

    bit            hold_pend = 1'b0;
    logic [TW-1:0] hold_tile;
    logic [CW-1:0] hold_bx, hold_by;
    logic          hold_last;

    task automatic check(input bit ok, input string tag, input logic [TW-1:0] act,
                         input logic [TW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Formula model for R3, R4, R5 with tile order of R2 and packing of R6.
    task automatic build_expect(input int w, input int h);
        int n, m, hs, vs, a, b, c, xc, yc, p, x, y, neg;
        logic [TW-1:0] t;
        n = w/2; m = h/2; hs = 0; vs = 0;
        for (int k = 1; k <= n; k++) begin
            neg = (n-1-k < 0) ? cv : tv[n-1-k];
            hs += k * (tv[n-1+k] - neg);
        end
        for (int k = 1; k <= m; k++) begin
            neg = (m-1-k < 0) ? cv : lv[m-1-k];
            vs += k * (lv[m-1+k] - neg);
        end
        a = 16 * (lv[h-1] + tv[w-1]);
        b = (((w == 16) ? 5 : 34) * hs + 32) >>> 6;
        c = (((h == 16) ? 5 : 34) * vs + 32) >>> 6;
        xc = (w == 16) ? 7 : 3;
        yc = (h == 16) ? 7 : 3;
        for (int by = 0; by < h/4; by++) begin
            for (int bx = 0; bx < w/4; bx++) begin
                t = '0;
                for (int j = 0; j < 4; j++) begin
                    for (int i = 0; i < 4; i++) begin
                        x = bx*4 + i; y = by*4 + j;
                        p = (a + b*(x-xc) + c*(y-yc) + 16) >>> 5;
                        if (p < 0) p = 0;
                        if (p > 255) p = 255;
                        t[(j*4+i)*8 +: 8] = p[7:0];
                    end
                end
                q_tile.push_back(t);
                q_bx.push_back(bx);
                q_by.push_back(by);
                q_last.push_back((bx == w/4-1) && (by == h/4-1));
            end
        end
    endtask

    task automatic fill_refs(input int pat);
        int f;
        f = $urandom_range(255);
        for (int x = 0; x < MAXD; x++) begin
            case (pat)
                1: begin tv[x] = 255; lv[x] = 0; end
                2: begin tv[x] = 255 - 15*x; lv[x] = 15*x; end
                3: begin tv[x] = f; lv[x] = f; end
                4: begin tv[x] = 0; lv[x] = 255; end
                default: begin tv[x] = $urandom_range(255); lv[x] = $urandom_range(255); end
            endcase
        end
        cv = (pat == 3) ? f : ((pat == 1) ? 128 : $urandom_range(255));
    endtask

    task automatic run_block(input bit chroma, input logic [1:0] fmt, input int pat,
                             input bit poke);
        int w, h;
        w = (!chroma || fmt == 2'd3) ? 16 : 8;
        h = (!chroma || fmt[1]) ? 16 : 8;
        fill_refs(pat);
        build_expect(w, h);
        @(negedge clk);
        for (int x = 0; x < MAXD; x++) begin
            top_row[x*8 +: 8]  = tv[x][7:0];
            left_col[x*8 +: 8] = lv[x][7:0];
        end
        corner     = cv[7:0];
        is_chroma  = chroma;
        chroma_fmt = fmt;
        exp_lat    = w/2 + h/2 + 2;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R9 busy after start", TW'(busy), TW'(1));
        // R8: inputs change while busy; the model keeps the sampled set.
        for (int x = 0; x < MAXD; x++) begin
            top_row[x*8 +: 8]  = 8'($urandom_range(255));
            left_col[x*8 +: 8] = 8'($urandom_range(255));
        end
        corner     = 8'($urandom_range(255));
        is_chroma  = ~chroma;
        chroma_fmt = fmt + 2'd1;
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        check(q_tile.size() == 0, "R2 tile count", TW'(q_tile.size()), TW'(0));
    endtask

    task automatic run_collision(input bit chroma, input logic [1:0] fmt);
        bit quiet;
        rdy_mode = 1'b1;
        collide_arm = 1'b1;
        run_block(chroma, fmt, 0, 1'b0);
        quiet = 1'b1;
        repeat (24) begin
            @(negedge clk);
            if (busy || out_valid) quiet = 1'b0;
        end
        check(quiet && !collide_arm, "R8 start on last handshake ignored",
              TW'({busy, out_valid, collide_arm}), TW'(0));
        rdy_mode = 1'b0;
    endtask

    // Ready changes just after each rising edge.
    always @(posedge clk) begin
        #1;
        out_ready = rdy_mode ? 1'b1 : ($urandom_range(3) != 0);
    end

    // Latency counter for R9.
    always @(posedge clk) begin
        cyc++;
        if (lat_track) lat_cnt++;
        else if (rst_n && start && !busy) begin
            lat_track = 1'b1;
            lat_cnt = 0;
        end
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog: actual cycles=%0d expected below %0d", cyc, 150000);
            summary_and_end();
        end
    end

    // Per-cycle monitor against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mon_start_clr) begin
                start = 1'b0;
                mon_start_clr = 1'b0;
            end
            if (hold_pend) begin
                check(out_valid && out_tile === hold_tile && out_bx === hold_bx &&
                      out_by === hold_by && out_last === hold_last,
                      "R7 stalled tile held", out_tile, hold_tile);
            end
            hold_pend = out_valid && !out_ready;
            hold_tile = out_tile;
            hold_bx   = out_bx;
            hold_by   = out_by;
            hold_last = out_last;
            if (lat_track && out_valid) begin
                check(lat_cnt == exp_lat, "R9 first tile latency", TW'(lat_cnt), TW'(exp_lat));
                lat_track = 1'b0;
            end
            if (out_valid && out_ready) begin
                if (q_tile.size() == 0) begin
                    check(1'b0, "R2 unexpected tile", out_tile, '0);
                end else begin
                    check(out_tile === q_tile[0], "R5 R6 tile samples", out_tile, q_tile[0]);
                    check(int'(out_bx) == q_bx[0] && int'(out_by) == q_by[0],
                          "R2 tile position", TW'({out_by, out_bx}),
                          TW'({2'(q_by[0]), 2'(q_bx[0])}));
                    check(out_last === q_last[0], "R2 last flag", TW'(out_last), TW'(q_last[0]));
                    void'(q_tile.pop_front());
                    void'(q_bx.pop_front());
                    void'(q_by.pop_front());
                    void'(q_last.pop_front());
                end
                if (collide_arm && out_last) begin
                    start = 1'b1;
                    mon_start_clr = 1'b1;
                    collide_arm = 1'b0;
                end
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(!busy && !out_valid, "R1 during reset", TW'({busy, out_valid}), TW'(0));
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !out_valid, "R1 after reset", TW'({busy, out_valid}), TW'(0));

        for (int pat = 0; pat < 5; pat++) begin
            run_block(1'b0, 2'd0, pat, pat[0]);
            run_block(1'b1, 2'd1, pat, 1'b0);
            run_block(1'b1, 2'd2, pat, pat[0]);
            run_block(1'b1, 2'd3, pat, 1'b0);
            run_block(1'b1, 2'd0, pat, 1'b1);
        end
        for (int r = 0; r < 20; r++) begin
            run_block(r[0], 2'(r % 4), 0, r[1]);
        end
        run_collision(1'b0, 2'd0);
        run_collision(1'b1, 2'd1);
        run_collision(1'b1, 2'd2);
        run_block(1'b1, 2'd3, 0, 1'b0);
        summary_and_end();
    end

endmodule